// File: doc/BRIEF.md
# Boot configuration reset sequencer

This block brings a device out of power-on reset. It first qualifies the board's active-low power-on reset input: only a low pulse that lasts long enough counts, and shorter pulses have no effect. After a qualified release it reads a fixed boot image from a serial boot memory one byte at a time, through a simple request/acknowledge interface. The image holds a 32-bit preamble, a 512-bit configuration word and a 32-bit CRC. The sequencer checks the preamble and the CRC and holds the device in hard reset for the whole fetch.

When the image is good, the block releases hard reset and hands over to an external pre-boot command executor. That executor runs the commands as opaque work and answers with done or error. On done the block declares the system ready and drops its not-ready indicator. Any failure in either phase raises the reset-request output. The failure is also latched as an error code in the 0x70 to 0x7A range. The sequencer then stops until a new qualified power-on reset or its synchronous reset arrives, so a debugger can inspect the device without a reset storm.

All three control outputs are registered. A failure in the fetch leaves hard reset asserted. A failure in the command phase leaves it released.

Top module: `boot_rst_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `hreset_n`=0, `rstreq_n`=1, `not_ready`=1, `rd_req`=0, `cmd_run`=0 and `err_code`=0x00. The sequencer then waits idle for a qualified power-on reset.
- R2: `por_n` counts as a valid power-on reset only after it has been sampled low on at least `POR_MIN_CYCLES` consecutive clock edges. A shorter low pulse changes nothing in any state. At the first edge that samples `por_n` high after a valid pulse, the sequencer restarts from any state: `rd_req`=1, `hreset_n`=0, `rstreq_n`=1, `err_code`=0x00.
- R3: The fetch reads byte addresses 0 to 71 in order, and a byte is taken on an edge where `rd_req` and `rd_ack` are both high. Bytes 0-3 are the preamble, most significant byte first. Bytes 4-67 are the configuration word, with byte 4 landing in `cfg_word[511:504]`. Bytes 68-71 are the CRC, most significant byte first. Acknowledge stalls of any length are tolerated.
- R4: `hreset_n` stays 0 throughout the fetch and the check. It rises on the same edge that `cmd_run` rises, one cycle after the last byte is taken, and only when both checks pass.
- R5: If the four preamble bytes differ from `PREAMBLE` (default 0xA55AC33C), the sequencer halts with code 0x70 on the edge that takes byte 3 and issues no further reads. A CRC mismatch halts it with code 0x72. The CRC is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, taken most significant bit first over bytes 4-67, with no final inversion. `hreset_n` stays 0 in both cases.
- R6: A taken byte with `rd_err`=1 (an illegal address) halts the sequencer at once with code 0x71, and no further read is issued. This check has priority over the preamble check.
- R7: `not_ready` stays 1 from reset until `cmd_done` is seen while `cmd_run`=1. From the next cycle it is 0, with `hreset_n`=1, `rstreq_n`=1 and `cmd_run`=0.
- R8: `cmd_err` seen while `cmd_run`=1 halts the sequencer with code 0x79, and it wins over a simultaneous `cmd_done`. In that halt `rstreq_n`=0, `hreset_n` stays 1 and `not_ready` stays 1.
- R9: In the halt state every input except a qualified power-on reset and `rst_n` is ignored, and all outputs hold. A valid power-on reset clears `err_code`, returns `rstreq_n` to 1 and restarts the fetch.
- R10: `err_code` is 0x00 whenever `rstreq_n`=1, and lies in 0x70 to 0x7A whenever `rstreq_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also restarts a halted sequencer |
| por_n | input | 1 | Board power-on reset, active low, qualified by length |
| rd_req | output | 1 | Byte read request to the boot memory, high during the fetch |
| rd_addr | output | ADDR_W | Byte address of the pending read |
| rd_ack | input | 1 | Memory returns a byte this cycle |
| rd_data | input | 8 | Returned byte |
| rd_err | input | 1 | Returned byte is invalid (illegal address) |
| cmd_run | output | 1 | Pre-boot command phase active |
| cmd_done | input | 1 | Executor finished all commands |
| cmd_err | input | 1 | Executor failed a command |
| hreset_n | output | 1 | Hard reset to the device, active low |
| rstreq_n | output | 1 | Reset request to the board, active low, set on failure |
| not_ready | output | 1 | High until the system-ready state |
| err_code | output | 8 | Latched failure code, 0x00 when none |
| cfg_word | output | CFG_BITS | Captured configuration word |

## Verification
The bench sweeps every power-on reset pulse length from 1 up to the threshold. A qualifier that is off by one would start a fetch on a pulse one cycle too short, or reject one of exactly the minimum length. A short pulse is also applied in the ready state; a design that reacts to it would drop ready or reassert hard reset. The bench corrupts each preamble, configuration and CRC byte in turn and places a read error at every address. Each of these must produce its own code, stop reading at the right byte and keep hard reset low. A design that checked late, continued reading or released hard reset early would show the wrong byte count, the wrong code or a high `hreset_n`. Further cases cover a command error in the same cycle as done, inputs that arrive during a halt, and fetches with acknowledge stalls. These catch wrong priority, a halt that can be left, and byte capture that depends on back-to-back acknowledges.

// File: rtl/boot_rst_pkg.sv
// Shared types and constants for the boot configuration reset sequencer.
// Assumes byte-serial boot memory and a 32-bit CRC transmitted MSB first.
package boot_rst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POR_WAIT,
        ST_RCW_LOAD,
        ST_RCW_CHECK,
        ST_PBI_RUN,
        ST_SYSTEM_READY,
        ST_ERROR_HALT
    } seq_state_t;

    localparam logic [7:0] ERR_NONE     = 8'h00;
    localparam logic [7:0] ERR_PREAMBLE = 8'h70;
    localparam logic [7:0] ERR_READ     = 8'h71;
    localparam logic [7:0] ERR_CRC      = 8'h72;
    localparam logic [7:0] ERR_CMD      = 8'h79;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    localparam int PRE_BYTES = 4;
    localparam int CRC_BYTES = 4;

endpackage

// File: rtl/boot_por_qual.sv
// Power-on reset qualifier. Counts consecutive edges with por_n low and
// saturates at MIN_CYCLES. Assumes por_n is already synchronised to clk.
// por_armed: still low after a full-length pulse. por_release: first high
// edge after a full-length pulse. Shorter pulses raise neither.
module boot_por_qual #(
    parameter int MIN_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    output logic por_armed,
    output logic por_release
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_CYCLES);

    logic [CW-1:0] low_cnt_q;

    // Count low edges, saturate at the limit, clear when por_n is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!por_n) begin
            if (low_cnt_q != LIMIT) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end else begin
            low_cnt_q <= '0;
        end
    end

    assign por_armed   = !por_n && (low_cnt_q == LIMIT);
    assign por_release =  por_n && (low_cnt_q == LIMIT);

endmodule

// File: rtl/boot_crc32_byte.sv
// Byte-wide CRC-32 accumulator: polynomial 0x04C11DB7, initial value all
// ones, data MSB first, no final inversion. clr has priority over en.
module boot_crc32_byte
    import boot_rst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    logic [31:0] crc_q;
    logic [31:0] crc_d;
    logic        fb;

    // Eight serial LFSR steps folded into one combinational update.
    always_comb begin
        crc_d = crc_q;
        fb    = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            fb    = crc_d[31] ^ din[i];
            crc_d = {crc_d[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
    end

    // Hold, clear or advance the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/boot_cfg_fetch.sv
// Boot image datapath: byte address counter, preamble shifter,
// configuration word capture, CRC accumulation and received CRC.
// Assumes the image layout preamble / config word / CRC, each MSB first.
module boot_cfg_fetch
    import boot_rst_pkg::*;
#(
    parameter int          CFG_BITS = 512,
    parameter logic [31:0] PREAMBLE = 32'hA55A_C33C,
    parameter int          ADDR_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                take,
    input  logic [7:0]          din,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                pre_last,
    output logic                pre_ok,
    output logic                last_byte,
    output logic                crc_good,
    output logic [CFG_BITS-1:0] cfg_word
);
    localparam int CFG_BYTES = CFG_BITS / 8;
    localparam int TOTAL     = PRE_BYTES + CFG_BYTES + CRC_BYTES;
    localparam int CW        = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] CFG_FIRST = CW'(PRE_BYTES);
    localparam logic [CW-1:0] CRC_FIRST = CW'(PRE_BYTES + CFG_BYTES);
    localparam logic [CW-1:0] PRE_END   = CW'(PRE_BYTES - 1);
    localparam logic [CW-1:0] LAST_IDX  = CW'(TOTAL - 1);

    logic [CW-1:0]       idx_q;
    logic [23:0]         pre_q;
    logic [31:0]         crc_rx_q;
    logic [CFG_BITS-1:0] cfg_q;
    logic [31:0]         crc_calc;
    logic                in_pre;
    logic                in_cfg;

    assign in_pre = idx_q < CFG_FIRST;
    assign in_cfg = (idx_q >= CFG_FIRST) && (idx_q < CRC_FIRST);

    // Byte index doubles as the read address.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            idx_q <= '0;
        end else if (take && idx_q != LAST_IDX) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Route each accepted byte into the field that owns its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            crc_rx_q <= '0;
            cfg_q    <= '0;
        end else if (take && !start) begin
            if (in_pre) begin
                pre_q <= {pre_q[15:0], din};
            end else if (in_cfg) begin
                cfg_q <= {cfg_q[CFG_BITS-9:0], din};
            end else begin
                crc_rx_q <= {crc_rx_q[23:0], din};
            end
        end
    end

    boot_crc32_byte u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (take && in_cfg),
        .din   (din),
        .crc   (crc_calc)
    );

    generate
        if (ADDR_W > CW) begin : g_addr_pad
            assign rd_addr = {{(ADDR_W - CW){1'b0}}, idx_q};
        end else begin : g_addr_trim
            assign rd_addr = idx_q[ADDR_W-1:0];
        end
    endgenerate

    assign pre_last  = idx_q == PRE_END;
    assign pre_ok    = {pre_q, din} == PREAMBLE;
    assign last_byte = idx_q == LAST_IDX;
    assign crc_good  = crc_rx_q == crc_calc;
    assign cfg_word  = cfg_q;

endmodule

// File: rtl/boot_seq_fsm.sv
// Reset sequencing state machine. Power-on reset events override every
// state. All control outputs are registered from the next state, so they
// change on the same edge as the state.
module boot_seq_fsm
    import boot_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_armed,
    input  logic       por_release,
    input  logic       rd_ack,
    input  logic       rd_err,
    input  logic       pre_last,
    input  logic       pre_ok,
    input  logic       last_byte,
    input  logic       crc_good,
    input  logic       cmd_done,
    input  logic       cmd_err,
    output logic       load_start,
    output logic       take,
    output logic       rd_req,
    output logic       cmd_run,
    output logic       hreset_n,
    output logic       rstreq_n,
    output logic       not_ready,
    output logic [7:0] err_code
);
    seq_state_t state_q, state_d;
    logic [7:0] err_q, err_d;
    logic       rdreq_q, cmdrun_q, hreset_q, rstreq_q, notready_q;

    assign take = rdreq_q && rd_ack;

    // Next state and next error code.
    always_comb begin
        state_d    = state_q;
        err_d      = err_q;
        load_start = 1'b0;
        if (por_release) begin
            state_d    = ST_RCW_LOAD;
            err_d      = ERR_NONE;
            load_start = 1'b1;
        end else if (por_armed) begin
            state_d = ST_POR_WAIT;
            err_d   = ERR_NONE;
        end else begin
            unique case (state_q)
                ST_RCW_LOAD: begin
                    if (take) begin
                        if (rd_err) begin
                            state_d = ST_ERROR_HALT;
                            err_d   = ERR_READ;
                        end else if (pre_last && !pre_ok) begin
                            state_d = ST_ERROR_HALT;
                            err_d   = ERR_PREAMBLE;
                        end else if (last_byte) begin
                            state_d = ST_RCW_CHECK;
                        end
                    end
                end
                ST_RCW_CHECK: begin
                    if (crc_good) begin
                        state_d = ST_PBI_RUN;
                    end else begin
                        state_d = ST_ERROR_HALT;
                        err_d   = ERR_CRC;
                    end
                end
                ST_PBI_RUN: begin
                    if (cmd_err) begin
                        state_d = ST_ERROR_HALT;
                        err_d   = ERR_CMD;
                    end else if (cmd_done) begin
                        state_d = ST_SYSTEM_READY;
                    end
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // State, error code and registered output decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= ERR_NONE;
            rdreq_q    <= 1'b0;
            cmdrun_q   <= 1'b0;
            hreset_q   <= 1'b0;
            rstreq_q   <= 1'b1;
            notready_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            err_q      <= err_d;
            rdreq_q    <= state_d == ST_RCW_LOAD;
            cmdrun_q   <= state_d == ST_PBI_RUN;
            hreset_q   <= (state_d == ST_PBI_RUN) || (state_d == ST_SYSTEM_READY)
                       || ((state_d == ST_ERROR_HALT) && hreset_q);
            rstreq_q   <= state_d != ST_ERROR_HALT;
            notready_q <= state_d != ST_SYSTEM_READY;
        end
    end

    assign rd_req    = rdreq_q;
    assign cmd_run   = cmdrun_q;
    assign hreset_n  = hreset_q;
    assign rstreq_n  = rstreq_q;
    assign not_ready = notready_q;
    assign err_code  = err_q;

endmodule

// File: rtl/boot_rst_seq.sv
// Boot configuration reset sequencer top. Joins the power-on reset
// qualifier, the boot image datapath and the sequencing state machine.
// Assumes por_n, rd_* and cmd_* are synchronous to clk.
module boot_rst_seq
    import boot_rst_pkg::*;
#(
    parameter int          CFG_BITS       = 512,
    parameter logic [31:0] PREAMBLE       = 32'hA55A_C33C,
    parameter int          POR_MIN_CYCLES = 50000,
    parameter int          ADDR_W         = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_ack,
    input  logic [7:0]          rd_data,
    input  logic                rd_err,
    output logic                cmd_run,
    input  logic                cmd_done,
    input  logic                cmd_err,
    output logic                hreset_n,
    output logic                rstreq_n,
    output logic                not_ready,
    output logic [7:0]          err_code,
    output logic [CFG_BITS-1:0] cfg_word
);
    logic por_armed, por_release;
    logic load_start, take;
    logic pre_last, pre_ok, last_byte, crc_good;

    boot_por_qual #(
        .MIN_CYCLES (POR_MIN_CYCLES)
    ) u_por (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_n       (por_n),
        .por_armed   (por_armed),
        .por_release (por_release)
    );

    boot_cfg_fetch #(
        .CFG_BITS (CFG_BITS),
        .PREAMBLE (PREAMBLE),
        .ADDR_W   (ADDR_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (load_start),
        .take      (take),
        .din       (rd_data),
        .rd_addr   (rd_addr),
        .pre_last  (pre_last),
        .pre_ok    (pre_ok),
        .last_byte (last_byte),
        .crc_good  (crc_good),
        .cfg_word  (cfg_word)
    );

    boot_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_armed   (por_armed),
        .por_release (por_release),
        .rd_ack      (rd_ack),
        .rd_err      (rd_err),
        .pre_last    (pre_last),
        .pre_ok      (pre_ok),
        .last_byte   (last_byte),
        .crc_good    (crc_good),
        .cmd_done    (cmd_done),
        .cmd_err     (cmd_err),
        .load_start  (load_start),
        .take        (take),
        .rd_req      (rd_req),
        .cmd_run     (cmd_run),
        .hreset_n    (hreset_n),
        .rstreq_n    (rstreq_n),
        .not_ready   (not_ready),
        .err_code    (err_code)
    );

endmodule

// File: rtl/boot_rst_seq_chk.sv
// Property checker for boot_rst_seq, attached by bind. Watches the ports
// plus the two qualified power-on reset events.
module boot_rst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_armed,
    input logic       por_release,
    input logic       rd_req,
    input logic       rd_ack,
    input logic       rd_err,
    input logic       cmd_run,
    input logic       cmd_done,
    input logic       cmd_err,
    input logic       hreset_n,
    input logic       rstreq_n,
    input logic       not_ready,
    input logic [7:0] err_code
);
    logic por_evt;
    assign por_evt = por_armed || por_release;

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_release |=> (rd_req && !hreset_n && rstreq_n && err_code == 8'h00));

    assert_hold_in_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !hreset_n);

    assert_release_with_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hreset_n) |-> cmd_run);

    assert_read_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err && !por_evt) |=>
            (!rstreq_n && err_code == 8'h71 && !rd_req));

    assert_ready_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !not_ready |-> (hreset_n && rstreq_n && !rd_req && !cmd_run));

    assert_cmd_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_run && cmd_err && !por_evt) |=>
            (!rstreq_n && hreset_n && not_ready && err_code == 8'h79));

    assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_run && cmd_done && !cmd_err && !por_evt) |=> !not_ready);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rstreq_n && !por_evt) |=>
            (!rstreq_n && $stable(err_code) && $stable(hreset_n) && !rd_req && !cmd_run));

    assert_code_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rstreq_n |-> (err_code == 8'h00));

    assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rstreq_n |-> (err_code >= 8'h70 && err_code <= 8'h7A));

endmodule

bind boot_rst_seq boot_rst_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_armed   (por_armed),
    .por_release (por_release),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .rd_err      (rd_err),
    .cmd_run     (cmd_run),
    .cmd_done    (cmd_done),
    .cmd_err     (cmd_err),
    .hreset_n    (hreset_n),
    .rstreq_n    (rstreq_n),
    .not_ready   (not_ready),
    .err_code    (err_code)
);

// File: tb/boot_rst_seq_test.sv
// Self-checking bench for boot_rst_seq with a short power-on reset threshold.
module boot_rst_seq_test;
    localparam int          MINC   = 8;
    localparam int          CFGB   = 512;
    localparam int          NBYTES = 72;
    localparam logic [31:0] PRE    = 32'hA55A_C33C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            por_n = 1'b1;
    logic            rd_req;
    logic [15:0]     rd_addr;
    logic            rd_ack = 1'b0;
    logic [7:0]      rd_data = 8'h00;
    logic            rd_err = 1'b0;
    logic            cmd_run;
    logic            cmd_done = 1'b0;
    logic            cmd_err = 1'b0;
    logic            hreset_n, rstreq_n, not_ready;
    logic [7:0]      err_code;
    logic [CFGB-1:0] cfg_word;

    int   errors = 0;
    int   checks = 0;
    logic [7:0] mem [0:NBYTES-1];
    logic [CFGB-1:0] exp_cfg;
    bit   stall_mode = 1'b0;
    bit   phase = 1'b0;
    int   err_addr = -1;
    int   acc = 0;
    int   hold_bad = 0;
    int   rise_bad = 0;
    logic prev_hr = 1'b0;

    boot_rst_seq #(.POR_MIN_CYCLES(MINC)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_err(rd_err),
        .cmd_run(cmd_run), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .hreset_n(hreset_n), .rstreq_n(rstreq_n), .not_ready(not_ready),
        .err_code(err_code), .cfg_word(cfg_word)
    );

    always #10 clk = ~clk;

    // Boot memory model and monitors, driven away from the active edge.
    always @(negedge clk) begin
        int a;
        a = int'(rd_addr);
        phase = ~phase;
        if (rd_req && hreset_n) hold_bad++;
        if (hreset_n && !prev_hr && !cmd_run) rise_bad++;
        prev_hr = hreset_n;
        if (rd_req && (!stall_mode || phase)) begin
            rd_ack  = 1'b1;
            rd_data = (a < NBYTES) ? mem[a] : 8'h00;
            rd_err  = (a == err_addr);
            acc++;
        end else begin
            rd_ack = 1'b0;
            rd_err = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [CFGB-1:0] w);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = CFGB - 1; i >= 0; i--) begin
            logic fb = c[31] ^ w[i];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
        end
        return c;
    endfunction

    task automatic build_image(input int seed);
        logic [31:0] c;
        for (int i = 0; i < 4; i++) mem[i] = PRE[31 - 8*i -: 8];
        for (int i = 0; i < 64; i++) begin
            mem[4 + i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
            exp_cfg[CFGB - 1 - 8*i -: 8] = mem[4 + i];
        end
        c = ref_crc(exp_cfg);
        for (int i = 0; i < 4; i++) mem[68 + i] = c[31 - 8*i -: 8];
    endtask

    task automatic por_pulse(input int n);
        @(negedge clk);
        por_n = 1'b0;
        repeat (n) @(negedge clk);
        por_n = 1'b1;
        acc = 0;
    endtask

    task automatic wait_outcome();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (hreset_n || !rstreq_n) return;
        end
    endtask

    task automatic good_boot(input int seed, input bit stall);
        build_image(seed);
        stall_mode = stall;
        err_addr = -1;
        por_pulse(MINC);
        wait_outcome();
        chk(hreset_n && cmd_run && rstreq_n && not_ready, "R4", "released into command phase",
            {hreset_n, cmd_run, rstreq_n, not_ready}, 4'b1111);
        chk(cfg_word == exp_cfg, "R3", "configuration word low bits",
            cfg_word[63:0], exp_cfg[63:0]);
        chk(cfg_word[511:448] == exp_cfg[511:448], "R3", "configuration word high bits",
            cfg_word[511:448], exp_cfg[511:448]);
        chk(acc == NBYTES, "R3", "bytes fetched", acc, NBYTES);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        build_image(0);
        repeat (3) @(negedge clk);
        chk({hreset_n, rstreq_n, not_ready, rd_req, cmd_run} == 5'b01100 && err_code == 0,
            "R1", "outputs in reset", {hreset_n, rstreq_n, not_ready, rd_req, cmd_run, err_code},
            13'b0110000000000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({hreset_n, rstreq_n, not_ready, rd_req} == 4'b0110, "R1", "idle after reset",
            {hreset_n, rstreq_n, not_ready, rd_req}, 4'b0110);

        // R2: every pulse shorter than the threshold is ignored.
        for (int n = 1; n < MINC; n++) begin
            por_pulse(n);
            repeat (3) @(negedge clk);
            chk(!rd_req && !hreset_n && rstreq_n, "R2", $sformatf("short pulse %0d ignored", n),
                {rd_req, hreset_n, rstreq_n}, 3'b001);
        end
        por_pulse(MINC);
        @(negedge clk);
        chk(rd_req && !hreset_n && rstreq_n, "R2", "minimum pulse starts fetch",
            {rd_req, hreset_n, rstreq_n}, 3'b101);
        wait_outcome();
        chk(hreset_n && cmd_run, "R4", "image accepted", {hreset_n, cmd_run}, 2'b11);
        chk(hold_bad == 0 && rise_bad == 0, "R4", "hard reset held during fetch",
            hold_bad + rise_bad, 0);

        // R7: ready only after done.
        repeat (5) @(negedge clk);
        chk(not_ready && cmd_run, "R7", "not ready during command phase",
            {not_ready, cmd_run}, 2'b11);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        chk(!not_ready && hreset_n && rstreq_n && !cmd_run, "R7", "system ready",
            {not_ready, hreset_n, rstreq_n, cmd_run}, 4'b0110);

        // R2: short pulse in ready state changes nothing.
        por_pulse(MINC - 1);
        repeat (4) @(negedge clk);
        chk(!not_ready && hreset_n && !rd_req, "R2", "short pulse ignored when ready",
            {not_ready, hreset_n, rd_req}, 3'b010);

        // R3 with stalled acknowledges, several images.
        for (int s = 1; s <= 3; s++) good_boot(s, s[0]);

        // R5: preamble corruption in each byte.
        for (int k = 0; k < 4; k++) begin
            build_image(7);
            mem[k] = mem[k] ^ 8'hFF;
            stall_mode = k[0];
            por_pulse(MINC);
            wait_outcome();
            chk(err_code == 8'h70 && !rstreq_n && !hreset_n, "R5",
                $sformatf("preamble byte %0d code", k), {err_code, rstreq_n, hreset_n}, {8'h70, 2'b00});
            chk(acc == 4 && !rd_req, "R5", $sformatf("preamble byte %0d stops reads", k), acc, 4);
        end

        // R5: CRC mismatch from any configuration or CRC byte.
        for (int k = 4; k < NBYTES; k++) begin
            build_image(k);
            mem[k] = mem[k] ^ (8'h01 << (k % 8));
            stall_mode = k[0];
            por_pulse(MINC);
            wait_outcome();
            chk(err_code == 8'h72 && !rstreq_n && !hreset_n && not_ready && acc == NBYTES, "R5",
                $sformatf("crc corrupt byte %0d", k), {err_code, rstreq_n, hreset_n, not_ready},
                {8'h72, 3'b001});
        end

        // R9: halt ignores everything but a qualified reset.
        cmd_done = 1'b1;
        cmd_err  = 1'b1;
        por_pulse(MINC - 1);
        repeat (20) @(negedge clk);
        cmd_done = 1'b0;
        cmd_err  = 1'b0;
        chk(err_code == 8'h72 && !rstreq_n && !hreset_n && !rd_req && !cmd_run, "R9",
            "halt holds", {err_code, rstreq_n, hreset_n, rd_req, cmd_run}, {8'h72, 4'b0000});
        build_image(2);
        @(negedge clk);
        por_n = 1'b0;
        repeat (MINC + 3) @(negedge clk);
        chk(rstreq_n && err_code == 0 && !hreset_n && !rd_req, "R9",
            "long reset clears halt", {rstreq_n, err_code, hreset_n, rd_req}, {1'b1, 8'h00, 2'b00});
        por_n = 1'b1;
        acc = 0;
        @(negedge clk);
        chk(rd_req, "R9", "fetch restarts after halt", rd_req, 1);
        wait_outcome();
        chk(hreset_n && rstreq_n && err_code == 0, "R10", "clean code after restart",
            {hreset_n, rstreq_n, err_code}, {2'b11, 8'h00});

        // R6: read error at every address.
        for (int a = 0; a < NBYTES; a++) begin
            build_image(a + 3);
            err_addr = a;
            stall_mode = a[1];
            por_pulse(MINC);
            wait_outcome();
            chk(err_code == 8'h71 && !rstreq_n && !hreset_n && acc == a + 1 && !rd_req, "R6",
                $sformatf("read error at %0d (bytes %0d)", a, acc), {err_code, rstreq_n, hreset_n},
                {8'h71, 2'b00});
        end
        err_addr = -1;

        // R8: command error, alone and together with done.
        for (int both = 0; both < 2; both++) begin
            good_boot(20 + both, 1'b0);
            repeat (2) @(negedge clk);
            cmd_err  = 1'b1;
            cmd_done = both[0];
            @(negedge clk);
            cmd_err  = 1'b0;
            cmd_done = 1'b0;
            chk(err_code == 8'h79 && !rstreq_n && hreset_n && not_ready && !cmd_run, "R8",
                $sformatf("command error (with done=%0d)", both),
                {err_code, rstreq_n, hreset_n, not_ready, cmd_run}, {8'h79, 4'b0110});
            repeat (10) @(negedge clk);
            chk(err_code == 8'h79 && hreset_n && !rstreq_n, "R9", "command halt holds",
                {err_code, hreset_n, rstreq_n}, {8'h79, 2'b10});
        end

        // R9: synchronous reset also leaves the halt.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rstreq_n && !hreset_n && not_ready && err_code == 0, "R9", "reset leaves halt",
            {rstreq_n, hreset_n, not_ready, err_code}, {3'b101, 8'h00});
        chk(hold_bad == 0 && rise_bad == 0, "R4", "no early release across all runs",
            hold_bad + rise_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule